// File: doc/BRIEF.md
# Command-Driven Conversion Sequencer

This block steers a sampling data converter through its operating modes. A 3-bit command arrives with a write strobe and selects one of five actions: low-power standby, a full calibration cycle, an offset auto-zero cycle, an abort back to idle, or continuous conversion. Calibration and auto-zero run as busy cycles of fixed, parameterised length and then return to idle. In the conversion mode the sequencer times an acquisition window whose length is one of four clock counts. It then either starts the conversion at once or waits for a rising edge on an external trigger pin. After each conversion-done strobe it re-enters acquisition, so conversions keep running until a different command is written.

The trigger pin is shared and its role follows the mode bit. In triggered mode the pin is an input; it passes through a two-stage synchronizer and an edge detector, and edges count only while the sequencer is armed. In free-running mode the block drives the pin as an output, and the pin stays high exactly while a conversion is in progress. A separate decoder turns the channel code into positive and negative multiplexer selects. Commands written during a busy cycle are held and take effect when that cycle ends. The abort command always acts at once.

Top module: `conv_sequencer`

## Requirements
- R1: During and directly after reset the sequencer is in standby: low_power_o=1, hold_o=0, start_conv_o=0, cal_pulse_o=0, az_pulse_o=0, mux_pos_o=0 and mux_neg_o=1.
- R2: Command codes are 000 standby (low_power_o high), 001 calibrate, 010 auto-zero, 011 abort to idle and 100 start. Codes 101, 110 and 111 are dropped with no effect. Calibrate and auto-zero each raise their one-cycle pulse in the first clock after the write edge.
- R3: The acquisition field selects 9, 15, 47 or 79 clocks for codes 00, 01, 10 and 11. In free-running mode start_conv_o is high during exactly the clock that follows the Nth rising edge after the edge that accepts start, and is low before that.
- R4: In triggered mode (sync_mode_i=1), the end of acquisition arms the sequencer without starting. A rising edge on sync_pin_i is synchronised through two flops, so hold_o and start_conv_o rise after the third clock edge from the pin change. A rising edge that occurs while not armed, including one during acquisition, is ignored.
- R5: sync_oe_o equals the inverse of sync_mode_i. In free-running mode sync_out_o is high exactly while hold_o is high. In triggered mode sync_out_o stays low.
- R6: hold_o rises together with the start_conv_o pulse and stays high until conv_done_i is sampled. The sequencer then re-enters acquisition and starts again after the same window.
- R7: A command written during a calibrate, auto-zero or conversion cycle does not act immediately. It is applied on the edge that ends that cycle. When several such commands are written, the latest one wins.
- R8: The abort command (011) takes effect on the edge that samples it in every state, and it discards any held command.
- R9: For channel codes 0000 to 0111, mux_pos_o equals the low three bits and mux_neg_o equals those bits with bit 0 inverted. For codes 1xxx, mux_pos_o=xxx and mux_neg_o=8, which means the common input. The outputs update one clock after the code changes.
- R10: A calibration cycle ends CAL_CYCLES clocks after the edge that enters it, and an auto-zero cycle ends AZ_CYCLES clocks after its entry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_code_i | input | 3 | Command code |
| acq_sel_i | input | 2 | Acquisition window select |
| sync_mode_i | input | 1 | 1 = triggered mode, pin is an input |
| chan_code_i | input | 4 | Channel code |
| conv_done_i | input | 1 | Conversion complete strobe |
| sync_pin_i | input | 1 | Trigger pin input value |
| hold_o | output | 1 | Sample held, conversion in progress |
| start_conv_o | output | 1 | One-cycle conversion start pulse |
| cal_pulse_o | output | 1 | One-cycle calibration start pulse |
| az_pulse_o | output | 1 | One-cycle auto-zero start pulse |
| low_power_o | output | 1 | Standby low-power enable |
| sync_oe_o | output | 1 | Trigger pin output enable |
| sync_out_o | output | 1 | Trigger pin driven value (busy) |
| mux_pos_o | output | 4 | Positive multiplexer select |
| mux_neg_o | output | 4 | Negative select, 8 = common |

## Verification
The bench sweeps all four acquisition windows and checks every cycle of each window. It also checks the window that follows each done strobe. A timer off by one clock shows up as a start pulse one cycle early or late. In triggered mode the bench times the pin-to-hold latency exactly, and it raises the pin during acquisition. A design that latched that early edge would begin a conversion that never should have started. The bench holds commands during calibration and conversion, aborts with a command pending, and sweeps all sixteen channel codes. A design that dropped or mis-ordered held commands would enter the wrong mode at the end of a cycle. A leaky abort would still enter standby later, and a wrong pairing shows directly on the selects.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_IDLE    = 3'd1,
        ST_CAL     = 3'd2,
        ST_AZ      = 3'd3,
        ST_ACQ     = 3'd4,
        ST_ARMED   = 3'd5,
        ST_CONV    = 3'd6
    } seq_state_e;

    localparam logic [2:0] CMD_STANDBY = 3'b000;
    localparam logic [2:0] CMD_CAL     = 3'b001;
    localparam logic [2:0] CMD_AZ      = 3'b010;
    localparam logic [2:0] CMD_ABORT   = 3'b011;
    localparam logic [2:0] CMD_START   = 3'b100;

endpackage

// File: rtl/seq_trig_sync.sv
module seq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R4
endmodule

// File: rtl/seq_chan_route.sv
module seq_chan_route #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH) + 1
) (
    input  logic [CW-1:0] code_i,
    output logic [CW-1:0] pos_o,
    output logic [CW-1:0] neg_o
);
    logic [CW-2:0] idx;

    always_comb begin
        idx   = code_i[CW-2:0];
        pos_o = {1'b0, idx};
        if (code_i[CW-1]) begin
            neg_o = CW'(NCH);
        end else begin
            neg_o = {1'b0, idx[CW-2:1], ~idx[0]};
        end
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                       cnt_d = load_val_i;
        else if (run_i && cnt_q > W'(1))  cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == W'(1));

    AST_TIMER_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q != '0); // R3
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CAL_CYCLES = 1024,
    parameter int AZ_CYCLES  = 64,
    parameter int ACQ_T0     = 9,
    parameter int ACQ_T1     = 15,
    parameter int ACQ_T2     = 47,
    parameter int ACQ_T3     = 79,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr_i,
    input  logic [2:0]             cmd_code_i,
    input  logic [1:0]             acq_sel_i,
    input  logic                   sync_mode_i,
    input  logic [$clog2(NCH):0]   chan_code_i,
    input  logic                   conv_done_i,
    input  logic                   sync_pin_i,
    output logic                   hold_o,
    output logic                   start_conv_o,
    output logic                   cal_pulse_o,
    output logic                   az_pulse_o,
    output logic                   low_power_o,
    output logic                   sync_oe_o,
    output logic                   sync_out_o,
    output logic [$clog2(NCH):0]   mux_pos_o,
    output logic [$clog2(NCH):0]   mux_neg_o
);
    localparam int SW = $clog2(NCH) + 1;
    localparam int TW = $clog2(CAL_CYCLES + AZ_CYCLES + ACQ_T0 + ACQ_T1 + ACQ_T2 + ACQ_T3 + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          pend_v;
        logic [2:0]    pend_c;
        logic          start_p;
        logic          cal_p;
        logic          az_p;
        logic [SW-1:0] pos;
        logic [SW-1:0] neg;
    } regs_t;

    regs_t d, q;

    logic          trig_rise;
    logic          tmr_expire;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_run;
    logic [SW-1:0] route_pos, route_neg;
    logic [TW-1:0] acq_len;
    logic          busy, finish, go, cmd_ok;
    logic [2:0]    go_code;

    seq_trig_sync #(.STAGES(SYNC_STAGES)) i_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sync_pin_i),
        .rise_o (trig_rise)
    );

    seq_chan_route #(.NCH(NCH)) i_route (
        .code_i (chan_code_i),
        .pos_o  (route_pos),
        .neg_o  (route_neg)
    );

    seq_timer #(.W(TW)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .expire_o   (tmr_expire)
    );

    always_comb begin
        case (acq_sel_i)
            2'd0:    acq_len = TW'(ACQ_T0);
            2'd1:    acq_len = TW'(ACQ_T1);
            2'd2:    acq_len = TW'(ACQ_T2);
            default: acq_len = TW'(ACQ_T3);
        endcase
    end

    assign tmr_run = (q.st == ST_CAL) || (q.st == ST_AZ) || (q.st == ST_ACQ);
    assign busy    = (q.st == ST_CAL) || (q.st == ST_AZ) || (q.st == ST_CONV);
    assign cmd_ok  = cmd_wr_i && (cmd_code_i <= CMD_START);

    always_comb begin
        d        = q;
        d.start_p = 1'b0;
        d.cal_p  = 1'b0;
        d.az_p   = 1'b0;
        d.pos    = route_pos;
        d.neg    = route_neg;
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        go       = 1'b0;
        go_code  = cmd_code_i;

        if (cmd_ok && cmd_code_i == CMD_ABORT) begin
            d.st     = ST_IDLE;
            d.pend_v = 1'b0;
        end else begin
            case (q.st)
                ST_CAL, ST_AZ: finish = tmr_expire;
                ST_CONV:       finish = conv_done_i;
                ST_ACQ: begin
                    if (tmr_expire) begin
                        if (sync_mode_i) begin
                            d.st = ST_ARMED;
                        end else begin
                            d.st      = ST_CONV;
                            d.start_p = 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (trig_rise) begin
                        d.st      = ST_CONV;
                        d.start_p = 1'b1;
                    end
                end
                default: ;
            endcase

            if (busy) begin
                if (cmd_ok) begin
                    d.pend_v = 1'b1;
                    d.pend_c = cmd_code_i;
                end
                if (finish) begin
                    if (d.pend_v) begin
                        go      = 1'b1;
                        go_code = d.pend_c;
                    end else if (q.st == ST_CONV) begin
                        go      = 1'b1;
                        go_code = CMD_START;
                    end else begin
                        d.st = ST_IDLE;
                    end
                    d.pend_v = 1'b0;
                end
            end else if (cmd_ok) begin
                go = 1'b1;
            end

            if (go) begin
                case (go_code)
                    CMD_STANDBY: d.st = ST_STANDBY;
                    CMD_CAL: begin
                        d.st     = ST_CAL;
                        d.cal_p  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(CAL_CYCLES);
                    end
                    CMD_AZ: begin
                        d.st     = ST_AZ;
                        d.az_p   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(AZ_CYCLES);
                    end
                    CMD_ABORT: d.st = ST_IDLE;
                    CMD_START: begin
                        d.st     = ST_ACQ;
                        tmr_load = 1'b1;
                        tmr_val  = acq_len;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.neg <= SW'(1);
        end else begin
            q <= d;
        end
    end

    assign hold_o       = (q.st == ST_CONV);
    assign start_conv_o = q.start_p;
    assign cal_pulse_o  = q.cal_p;
    assign az_pulse_o   = q.az_p;
    assign low_power_o  = (q.st == ST_STANDBY);
    assign sync_oe_o    = ~sync_mode_i;
    assign sync_out_o   = ~sync_mode_i & hold_o;
    assign mux_pos_o    = q.pos;
    assign mux_neg_o    = q.neg;

    AST_START_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv_o |-> hold_o); // R6
    AST_HOLD_RISES_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> start_conv_o); // R6
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !conv_done_i && !(cmd_wr_i && cmd_code_i == CMD_ABORT)) |=> hold_o); // R6
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_conv_o, cal_pulse_o, az_pulse_o}) <= 1); // R2
    AST_ABORT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_code_i == CMD_ABORT) |=> (!hold_o && !low_power_o && !cal_pulse_o && !az_pulse_o)); // R8
    AST_STANDBY_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_o |-> !sync_out_o); // R5
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
    localparam int CAL = 24;
    localparam int AZ  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] acq_sel = 2'd0;
    logic       sync_mode = 1'b0;
    logic [3:0] chan = 4'd0;
    logic       conv_done = 1'b0;
    logic       sync_pin = 1'b0;
    logic       hold, start_conv, cal_p, az_p, low_power, sync_oe, sync_out;
    logic [3:0] mpos, mneg;

    int checks = 0;
    int fails  = 0;

    conv_sequencer #(.NCH(8), .CAL_CYCLES(CAL), .AZ_CYCLES(AZ)) i_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_code_i(cmd_code),
        .acq_sel_i(acq_sel), .sync_mode_i(sync_mode), .chan_code_i(chan),
        .conv_done_i(conv_done), .sync_pin_i(sync_pin), .hold_o(hold),
        .start_conv_o(start_conv), .cal_pulse_o(cal_p), .az_pulse_o(az_p),
        .low_power_o(low_power), .sync_oe_o(sync_oe), .sync_out_o(sync_out),
        .mux_pos_o(mpos), .mux_neg_o(mneg)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_cmd(input logic [2:0] c);
        cmd_code = c;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic pulse_done();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Called right after the accepting edge; checks each cycle of the window.
    task automatic acq_window(input int n, input bit fire, input string tag);
        chk({tag, " start low at entry"}, int'(start_conv), 0);
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            chk({tag, " start timing"}, int'(start_conv), (fire && j == n) ? 1 : 0);
        end
    endtask

    function automatic int acq_len(input int s);
        case (s)
            0: return 9;
            1: return 15;
            2: return 47;
            default: return 79;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 low_power", int'(low_power), 1);
        chk("R1 hold", int'(hold), 0);
        chk("R1 pulses", int'({start_conv, cal_p, az_p}), 0);
        chk("R1 mux_pos", int'(mpos), 0);
        chk("R1 mux_neg", int'(mneg), 1);
        chk("R5 oe free-running", int'(sync_oe), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 standby after reset", int'(low_power), 1);

        // R9 channel sweep
        for (int c = 0; c < 16; c++) begin
            chan = 4'(c);
            @(negedge clk);
            chk("R9 pos", int'(mpos), c & 7);
            chk("R9 neg", int'(mneg), (c >= 8) ? 8 : ((c & 7) ^ 1));
        end

        // R2 undefined codes dropped
        for (int c = 5; c < 8; c++) begin
            write_cmd(3'(c));
            @(negedge clk);
            chk("R2 undefined code ignored", int'(low_power), 1);
            chk("R2 undefined no pulse", int'({start_conv, cal_p, az_p, hold}), 0);
        end
        write_cmd(3'b011);
        chk("R2 abort leaves standby", int'(low_power), 0);

        // R3 R5 R6 free-running sweep
        for (int s = 0; s < 4; s++) begin
            acq_sel = 2'(s);
            write_cmd(3'b100);
            acq_window(acq_len(s), 1'b1, "R3 first");
            chk("R6 hold with start", int'(hold), 1);
            chk("R5 busy out", int'(sync_out), 1);
            chk("R5 oe", int'(sync_oe), 1);
            repeat (3) @(negedge clk);
            chk("R6 hold stays", int'(hold), 1);
            chk("R3 single start pulse", int'(start_conv), 0);
            pulse_done();
            chk("R6 hold drops on done", int'(hold), 0);
            chk("R5 busy out drops", int'(sync_out), 0);
            acq_window(acq_len(s), 1'b1, "R6 reacquire");
            chk("R6 hold again", int'(hold), 1);
            pulse_done();
            write_cmd(3'b011);
        end

        // R7 pending commands during conversion, latest wins; R10 cal length
        acq_sel = 2'd0;
        write_cmd(3'b100);
        acq_window(9, 1'b1, "R3 pre-pend");
        write_cmd(3'b010);
        write_cmd(3'b001);
        chk("R7 held during conv", int'(hold), 1);
        chk("R7 no pulse yet", int'({cal_p, az_p}), 0);
        pulse_done();
        chk("R7 latest cmd applied (cal)", int'(cal_p), 1);
        chk("R7 earlier cmd dropped (az)", int'(az_p), 0);
        chk("R7 conv ended", int'(hold), 0);
        write_cmd(3'b000);
        for (int j = 2; j <= CAL; j++) begin
            @(negedge clk);
            chk("R10 cal length", int'(low_power), (j == CAL) ? 1 : 0);
        end

        // R10 auto-zero length
        write_cmd(3'b010);
        chk("R2 az pulse", int'(az_p), 1);
        chk("R2 leaves standby", int'(low_power), 0);
        write_cmd(3'b000);
        chk("R2 az pulse one cycle", int'(az_p), 0);
        for (int j = 2; j <= AZ; j++) begin
            @(negedge clk);
            chk("R10 az length", int'(low_power), (j == AZ) ? 1 : 0);
        end

        // R7 standby held during conversion
        write_cmd(3'b100);
        acq_window(9, 1'b1, "R3 standby-pend");
        write_cmd(3'b000);
        chk("R7 standby held", int'(low_power), 0);
        chk("R7 conv continues", int'(hold), 1);
        pulse_done();
        chk("R7 standby applied", int'(low_power), 1);
        chk("R7 hold off", int'(hold), 0);

        // R8 abort discards pending, aborts cal and conv
        write_cmd(3'b001);
        write_cmd(3'b000);
        write_cmd(3'b011);
        chk("R8 abort in cal", int'(low_power), 0);
        repeat (CAL + 4) @(negedge clk);
        chk("R8 pending discarded", int'(low_power), 0);
        write_cmd(3'b100);
        acq_window(9, 1'b1, "R3 pre-abort");
        write_cmd(3'b011);
        chk("R8 abort in conv", int'(hold), 0);
        repeat (12) @(negedge clk);
        chk("R8 no restart", int'(hold), 0);

        // R4 R5 triggered mode
        sync_mode = 1'b1;
        @(negedge clk);
        chk("R5 oe in triggered", int'(sync_oe), 0);
        write_cmd(3'b100);
        acq_window(9, 1'b0, "R4 no self start");
        repeat (10) @(negedge clk);
        chk("R4 armed waits", int'(hold), 0);
        sync_pin = 1'b1;
        @(negedge clk);
        chk("R4 latency 1", int'(hold), 0);
        @(negedge clk);
        chk("R4 latency 2", int'(hold), 0);
        @(negedge clk);
        chk("R4 latency 3 hold", int'(hold), 1);
        chk("R4 start pulse", int'(start_conv), 1);
        chk("R5 pin not driven", int'(sync_out), 0);
        pulse_done();
        chk("R6 triggered done", int'(hold), 0);
        sync_pin = 1'b0;
        repeat (2) @(negedge clk);
        sync_pin = 1'b1;
        repeat (25) @(negedge clk);
        chk("R4 edge during acquisition ignored", int'(hold), 0);
        sync_pin = 1'b0;
        repeat (3) @(negedge clk);
        sync_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 rearm latency", int'(hold), 0);
        @(negedge clk);
        chk("R4 rearm hold", int'(hold), 1);
        write_cmd(3'b011);
        chk("R8 abort triggered conv", int'(hold), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule